// File: doc/BRIEF.md
# Two-Line Steerable Interrupt Controller

This block gathers level-sensitive interrupt requests from up to nineteen on-chip peripheral sources. It qualifies each request with a per-source mask bit. A per-source routing bit then sends the request to exactly one of two processor request lines: a low-priority line and a high-priority line. A global enable bit gates both lines. While it is clear, the processor sees no request, but the pending status stays visible to software.

Software reaches the block through a small word-aligned register bus. A set-style register and a clear-style register manage the mask, so mask bits never need a read-modify-write. A routing register holds the steering bits, and there are two pending-status registers, one for each output line. Only source positions 0 to 10, 12, 17 and 18 are implemented. Every other position reads as zero everywhere.

Top module: `intc_dual_route`

## Requirements
- R1: After synchronous reset, the mask, the routing bits and the global enable are all zero, both request lines are low, and every register reads zero.
- R2: A write to 0x34 sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged. Data bit 31 of that write sets the global enable. A read of 0x34 or 0x38 returns the mask in bits 18:0 and the global enable in bit 31.
- R3: A write to 0x38 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged. Data bit 31 of that write clears the global enable, so writing all ones masks everything.
- R4: A write to 0x20 loads the routing bits, and a read of 0x20 returns them. A routing bit of 1 steers that source to the high line, and 0 steers it to the low line.
- R5: One clock edge after the inputs settle, the status register at 0x00 holds request AND mask AND NOT routing. The status register at 0x04 holds request AND mask AND routing.
- R6: Positions 11 and 13 to 16 of the mask, routing and status registers always read zero, whatever is written or requested.
- R7: irq_lo is registered and equals the global enable AND the OR of the low status bits. irq_hi does the same for the high status bits, on the same edge.
- R8: While the global enable is clear, neither request line asserts, but both status registers still report pending sources.
- R9: No source is ever pending in both status registers at once.
- R10: Requests are level-sensitive. A status bit, and its line, drops on the first edge after its request or its mask bit falls, with no latching.
- R11: Read data appears on bus_rdata on the edge after a cycle with bus_rd high. Unmapped addresses read zero, and writes to the status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 19 | Level request per source position |
| irq_lo | output | 1 | Low-priority processor request |
| irq_hi | output | 1 | High-priority processor request |

## Verification
The bench builds the block with its defaults: nineteen source positions, the sparse implemented set, and a 32-bit data path. These values make the holes at 11 and 13 to 16 reachable, so all-ones writes and all-ones requests show those positions held at zero. Routing a mix of sources to both lines makes the exclusivity rule and the independent gating by the global enable observable at the ports.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam logic [7:0] ADDR_STAT_LO = 8'h00;
  localparam logic [7:0] ADDR_STAT_HI = 8'h04;
  localparam logic [7:0] ADDR_ROUTE   = 8'h20;
  localparam logic [7:0] ADDR_SET     = 8'h34;
  localparam logic [7:0] ADDR_CLR     = 8'h38;
endpackage

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int unsigned NSRC = 19,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8,
  parameter logic [NSRC-1:0] IMPL_MASK = 19'h617FF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] route_q,
  output logic            gen_q
);
  import intc_pkg::*;
  localparam int unsigned GBIT = DW - 1;

  logic [NSRC-1:0] wbits;
  assign wbits = wdata[NSRC-1:0] & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      route_q <= '0;
      gen_q   <= 1'b0;
    end else if (wr_en) begin
      if (addr == AW'(ADDR_ROUTE)) begin
        route_q <= wbits;
      end else if (addr == AW'(ADDR_SET)) begin
        mask_q <= mask_q | wbits;
        if (wdata[GBIT]) gen_q <= 1'b1;
      end else if (addr == AW'(ADDR_CLR)) begin
        mask_q <= mask_q & ~wbits;
        if (wdata[GBIT]) gen_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int unsigned NSRC = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] mask_q,
  input  logic [NSRC-1:0] route_q,
  input  logic            gen_q,
  output logic [NSRC-1:0] stat_lo,
  output logic [NSRC-1:0] stat_hi,
  output logic            irq_lo,
  output logic            irq_hi
);
  logic [NSRC-1:0] nxt_lo;
  logic [NSRC-1:0] nxt_hi;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic live;
    assign live      = raw[i] & mask_q[i];
    assign nxt_lo[i] = live & ~route_q[i];
    assign nxt_hi[i] = live &  route_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_lo <= '0;
      stat_hi <= '0;
      irq_lo  <= 1'b0;
      irq_hi  <= 1'b0;
    end else begin
      stat_lo <= nxt_lo;
      stat_hi <= nxt_hi;
      irq_lo  <= gen_q & (|nxt_lo);
      irq_hi  <= gen_q & (|nxt_hi);
    end
  end
endmodule

// File: rtl/intc_rdmux.sv
module intc_rdmux #(
  parameter int unsigned NSRC = 19,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] stat_lo,
  input  logic [NSRC-1:0] stat_hi,
  input  logic [NSRC-1:0] mask_q,
  input  logic [NSRC-1:0] route_q,
  input  logic            gen_q,
  output logic [DW-1:0]   rdata
);
  import intc_pkg::*;
  localparam int unsigned PADW = DW - NSRC;
  localparam int unsigned GPAD = DW - 1 - NSRC;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == AW'(ADDR_STAT_LO))      rdata <= {{PADW{1'b0}}, stat_lo};
      else if (addr == AW'(ADDR_STAT_HI)) rdata <= {{PADW{1'b0}}, stat_hi};
      else if (addr == AW'(ADDR_ROUTE))   rdata <= {{PADW{1'b0}}, route_q};
      else if (addr == AW'(ADDR_SET) || addr == AW'(ADDR_CLR))
        rdata <= {gen_q, {GPAD{1'b0}}, mask_q};
      else
        rdata <= '0;
    end
  end
endmodule

// File: rtl/intc_dual_route.sv
module intc_dual_route #(
  parameter int unsigned NSRC = 19,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8,
  parameter logic [NSRC-1:0] IMPL_MASK = 19'h617FF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] irq_src,
  output logic            irq_lo,
  output logic            irq_hi
);
  logic [NSRC-1:0] mask_q, route_q, stat_lo, stat_hi;
  logic            gen_q;

  intc_regs #(.NSRC(NSRC), .DW(DW), .AW(AW), .IMPL_MASK(IMPL_MASK)) regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mask_q(mask_q), .route_q(route_q), .gen_q(gen_q));

  intc_route #(.NSRC(NSRC)) route_i (
    .clk(clk), .rst(rst), .raw(irq_src), .mask_q(mask_q), .route_q(route_q),
    .gen_q(gen_q), .stat_lo(stat_lo), .stat_hi(stat_hi),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  intc_rdmux #(.NSRC(NSRC), .DW(DW), .AW(AW)) rdmux_i (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .addr(bus_addr),
    .stat_lo(stat_lo), .stat_hi(stat_hi), .mask_q(mask_q),
    .route_q(route_q), .gen_q(gen_q), .rdata(bus_rdata));
endmodule

// File: rtl/intc_dual_route_chk.sv
module intc_dual_route_chk #(
  parameter int unsigned NSRC = 19,
  parameter logic [NSRC-1:0] IMPL_MASK = 19'h617FF
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] irq_src,
  input logic            irq_lo,
  input logic            irq_hi,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] route_q,
  input logic            gen_q,
  input logic [NSRC-1:0] stat_lo,
  input logic [NSRC-1:0] stat_hi
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!irq_lo && !irq_hi && mask_q == '0 && route_q == '0 && !gen_q));
  // R6
  holes_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((mask_q | route_q | stat_lo | stat_hi) & ~IMPL_MASK) == '0);
  // R7
  lo_line_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_q && ((irq_src & mask_q & ~route_q) != '0)) |=> irq_lo);
  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !gen_q |=> (!irq_lo && !irq_hi));
  // R9
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_lo & stat_hi) == '0);
  // R10
  level_drop_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_lo | stat_hi) & ~$past(irq_src & mask_q)) == '0);
endmodule

bind intc_dual_route intc_dual_route_chk #(.NSRC(NSRC), .IMPL_MASK(IMPL_MASK)) chk_i (
  .clk(clk), .rst(rst), .irq_src(irq_src), .irq_lo(irq_lo), .irq_hi(irq_hi),
  .mask_q(mask_q), .route_q(route_q), .gen_q(gen_q),
  .stat_lo(stat_lo), .stat_hi(stat_hi));

// File: tb/intc_dual_route_tb_top.sv
module intc_dual_route_tb_top;
  localparam int CLK_NS = 10;
  localparam int NSRC = 19;
  localparam logic [31:0] IMPL = 32'h0006_17FF;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NSRC-1:0] irq_src = '0;
  logic irq_lo, irq_hi;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;
  bit done = 1'b0;

  logic [31:0] m_mask = '0, m_route = '0;
  logic m_gen = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  intc_dual_route dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  function automatic logic [31:0] exp_lo();
    return {13'b0, irq_src} & m_mask & ~m_route & IMPL;
  endfunction
  function automatic logic [31:0] exp_hi();
    return {13'b0, irq_src} & m_mask & m_route & IMPL;
  endfunction
  function automatic logic [31:0] exp_en();
    return {m_gen, 31'b0} | (m_mask & IMPL);
  endfunction

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compares each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_lines(input logic el, input logic eh, input string t);
    n_cmp++;
    if (irq_lo !== el || irq_hi !== eh) begin
      n_bad++;
      $display("FAIL %s: lo/hi actual=%b%b expected=%b%b", t, irq_lo, irq_hi, el, eh);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    chk_lines(1'b0, 1'b0, "R1 reset lines");
    rd(8'h34, 32'h0, "R1 reset mask");
    rd(8'h20, 32'h0, "R1 reset route");
    rd(8'h00, 32'h0, "R1 reset stat lo");

    // R4 / R6: routing register, holes stay zero
    wr(8'h20, 32'hFFFF_FFFF); m_route = IMPL;
    rd(8'h20, IMPL, "R6 route holes");
    wr(8'h20, 32'h0006_0482); m_route = 32'h0006_0482 & IMPL;
    rd(8'h20, m_route, "R4 route readback");

    // R2: set-enable keeps other bits
    wr(8'h34, 32'h8000_0003); m_mask = 32'h3; m_gen = 1'b1;
    rd(8'h38, exp_en(), "R2 set mask and gen");
    wr(8'h34, 32'h0000_1000); m_mask |= 32'h1000;
    rd(8'h34, exp_en(), "R2 set keeps others");

    // R5/R7: all sources request
    irq_src = '1;
    idle(2);
    rd(8'h00, exp_lo(), "R5 stat lo");
    rd(8'h04, exp_hi(), "R5 stat hi");
    chk_lines(1'b1, 1'b1, "R7 lines with lo/hi pending");

    wr(8'h34, 32'hFFFF_FFFF); m_mask = IMPL;
    idle(2);
    rd(8'h00, exp_lo(), "R6 stat lo holes");
    rd(8'h04, exp_hi(), "R9 stat hi exclusive of lo");
    rd(8'h34, exp_en(), "R6 mask holes");

    // R8: global gate off
    wr(8'h38, 32'h8000_0000); m_gen = 1'b0;
    idle(2);
    chk_lines(1'b0, 1'b0, "R8 gate off lines");
    rd(8'h04, exp_hi(), "R8 status kept while gated");
    rd(8'h38, exp_en(), "R3 gen cleared mask kept");
    wr(8'h34, 32'h8000_0000); m_gen = 1'b1;
    idle(2);
    chk_lines(1'b1, 1'b1, "R8 gate back on");

    // R10: level behaviour on the low line with a single source
    irq_src = 19'h1;
    idle(2);
    chk_lines(1'b1, 1'b0, "R10 single low source");
    irq_src = '0;
    @(negedge clk);
    chk_lines(1'b0, 1'b0, "R10 drop after one edge");
    rd(8'h00, 32'h0, "R10 stat lo cleared");

    // R3/R10: mask clear removes a high source
    irq_src = 19'h20000;
    idle(2);
    chk_lines(1'b0, 1'b1, "R4 high route");
    wr(8'h38, 32'h0002_0000); m_mask &= ~32'h0002_0000;
    @(negedge clk);
    chk_lines(1'b0, 1'b0, "R10 mask drop");
    rd(8'h04, exp_hi(), "R3 clear one bit");

    // R11: unmapped read and status write ignored
    rd(8'h10, 32'h0, "R11 unmapped read");
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h34, exp_en(), "R11 status write ignored");

    // R3: all ones masks everything
    irq_src = '1;
    wr(8'h38, 32'hFFFF_FFFF); m_mask = '0; m_gen = 1'b0;
    idle(2);
    rd(8'h38, 32'h0, "R3 clear all");
    rd(8'h00, 32'h0, "R3 stat lo empty");
    chk_lines(1'b0, 1'b0, "R3 lines quiet");

    idle(3);
    finish_run();
  end
endmodule